// File: doc/BRIEF.md
# PHY Management Register Responder

This block stands in for an Ethernet PHY on the management side. It holds a bank of thirty-two 16-bit registers and answers requests that carry a PHY address. A controller-side agent issues a request on a parallel port. The request has a valid strobe, a 5-bit PHY address, a 5-bit register number, a 2-bit op code and 16-bit write data. One cycle later the block raises a done pulse and, for reads, presents the read data.

Most registers are plain storage. The status, link-partner and diagnostic registers are computed when read, from the link state and the advertisement register. A driver therefore sees autonegotiation complete as soon as it has written its advertisement. The link state follows the `link_up_i` input through one register.

Top module: `phy_mgmt_responder`

## Requirements
- R1: After reset, register 0 reads 0x3100, register 2 reads 0x0300, register 3 reads 0xE400 and register 4 reads 0x01E1. Every other stored register reads 0, the link state is up, and the outputs are low and zero.
- R2: Op code 2'b01 is a write and 2'b10 is a read. `rsp_done_o` is high for exactly the one cycle after each cycle in which `req_valid_i` is high, and it is low otherwise.
- R3: A write to the configured PHY address stores `req_wdata_i` unchanged in register `req_reg_i`, and a later read of a storage register returns that value.
- R4: A read of register 1 returns 0x782E when the link is up (bits 14, 13, 12, 11, 5, 3, 2 and 1) and 0x0000 when the link is down.
- R5: A read of register 5 returns 0x4001 OR (register 4 AND 0x01E0), whatever the link state.
- R6: A read of register 17 always returns 0x8000, even after a write to register 17.
- R7: A read of register 18 returns 0 when the link is down. When the link is up, bit 10 is register 4 bit 7 OR bit 8, bit 11 is register 4 bit 8 OR bit 6, and all other bits are 0.
- R8: A read whose PHY address differs from the parameter `PHY_ADDR` (default 7) returns 0xFFFF. A write to a different address changes no register.
- R9: A request with op code 2'b00 or 2'b11 changes no register and leaves the read data alone. It raises `rsp_bad_op_o` together with its done pulse.
- R10: `rsp_rdata_o` changes only in the cycle after a read request. Writes, invalid ops and idle cycles hold it.
- R11: The link state takes the value of `link_up_i` one cycle later. A read issued in the same cycle as a change on `link_up_i` uses the link state from before the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| link_up_i | input | 1 | Link indication, sampled every cycle |
| req_valid_i | input | 1 | Request strobe, one cycle per request |
| req_phy_i | input | 5 | Target PHY address |
| req_reg_i | input | 5 | Register number |
| req_op_i | input | 2 | 01 write, 10 read, others invalid |
| req_wdata_i | input | 16 | Write data |
| rsp_done_o | output | 1 | Pulse one cycle after a request |
| rsp_rdata_o | output | 16 | Read data, held until the next read |
| rsp_bad_op_o | output | 1 | Pulse with done for an invalid op code |

## Verification
Two things can land on the same clock edge: a change of the link input and a status read that depends on it. The bench drops `link_up_i` in the same cycle that it issues a read of register 1. It expects the full link-up value 0x782E from that read, and 0x0000 from the read that follows. A second overlap is a write to the advertisement register followed in the next cycle by a read of the derived registers 5 and 18. The bench judges both derived values against register 4 as just written.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int unsigned REG_AW = 5;
  localparam int unsigned DATA_W = 16;

  typedef logic [REG_AW-1:0] reg_idx_t;
  typedef logic [DATA_W-1:0] reg_data_t;

  typedef enum logic [1:0] {
    OP_RSVD0 = 2'b00,
    OP_WR    = 2'b01,
    OP_RD    = 2'b10,
    OP_RSVD3 = 2'b11
  } mgmt_op_e;

  localparam reg_idx_t IDX_STATUS  = 5'd1;
  localparam reg_idx_t IDX_ADV     = 5'd4;
  localparam reg_idx_t IDX_PARTNER = 5'd5;
  localparam reg_idx_t IDX_SPEED   = 5'd17;
  localparam reg_idx_t IDX_DIAG    = 5'd18;

  localparam reg_data_t STATUS_UP    = 16'h782E;
  localparam reg_data_t PARTNER_BASE = 16'h4001;
  localparam reg_data_t PARTNER_MASK = 16'h01E0;
  localparam reg_data_t SPEED_FIXED  = 16'h8000;

  function automatic reg_data_t reg_init(int unsigned idx);
    case (idx)
      0:       return 16'h3100;
      2:       return 16'h0300;
      3:       return 16'hE400;
      4:       return 16'h01E1;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/phy_reg_store.sv
module phy_reg_store
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned IDX_W = REG_AW
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_en_i,
  input  reg_idx_t  wr_idx_i,
  input  reg_data_t wr_data_i,
  input  reg_idx_t  rd_idx_i,
  output reg_data_t rd_data_o,
  output reg_data_t adv_o
);
  localparam int unsigned N_REGS = 1 << IDX_W;

  reg_data_t regs_q [N_REGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_REGS; i++) regs_q[i] <= reg_init(i);
    end else if (wr_en_i) begin
      regs_q[wr_idx_i] <= wr_data_i;
    end
  end

  assign rd_data_o = regs_q[rd_idx_i];
  assign adv_o     = regs_q[IDX_ADV];

  // R3: the advertisement word moves only when written
  p_adv_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_idx_i == IDX_ADV) |=> $stable(adv_o));
endmodule

// File: rtl/phy_read_view.sv
module phy_read_view
  import phy_mgmt_pkg::*;
(
  input  reg_idx_t  idx_i,
  input  reg_data_t stored_i,
  input  reg_data_t adv_i,
  input  logic      link_i,
  output reg_data_t view_o
);
  always_comb begin
    case (idx_i)
      IDX_STATUS:  view_o = link_i ? STATUS_UP : '0;
      IDX_PARTNER: view_o = PARTNER_BASE | (adv_i & PARTNER_MASK);
      IDX_SPEED:   view_o = SPEED_FIXED;
      IDX_DIAG:    view_o = link_i ?
                     {4'b0, adv_i[8] | adv_i[6], adv_i[8] | adv_i[7], 10'b0} : '0;
      default:     view_o = stored_i;
    endcase
  end
endmodule

// File: rtl/phy_link_track.sv
module phy_link_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic link_up_i,
  output logic link_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) link_o <= 1'b1;
    else         link_o <= link_up_i;
  end
endmodule

// File: rtl/phy_mgmt_responder.sv
module phy_mgmt_responder
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned PHY_ADDR = 7
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        link_up_i,
  input  logic        req_valid_i,
  input  logic [4:0]  req_phy_i,
  input  logic [4:0]  req_reg_i,
  input  logic [1:0]  req_op_i,
  input  logic [15:0] req_wdata_i,
  output logic        rsp_done_o,
  output logic [15:0] rsp_rdata_o,
  output logic        rsp_bad_op_o
);
  localparam reg_idx_t OWN_ADDR = REG_AW'(PHY_ADDR);

  logic      addr_hit, is_wr, is_rd, link_q;
  reg_data_t stored, adv, view;

  assign addr_hit = (req_phy_i == OWN_ADDR);
  assign is_wr    = (req_op_i == OP_WR);
  assign is_rd    = (req_op_i == OP_RD);

  phy_link_track u_link (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .link_up_i (link_up_i),
    .link_o    (link_q)
  );

  phy_reg_store #(.IDX_W(REG_AW)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (req_valid_i && addr_hit && is_wr),
    .wr_idx_i  (req_reg_i),
    .wr_data_i (req_wdata_i),
    .rd_idx_i  (req_reg_i),
    .rd_data_o (stored),
    .adv_o     (adv)
  );

  phy_read_view u_view (
    .idx_i    (req_reg_i),
    .stored_i (stored),
    .adv_i    (adv),
    .link_i   (link_q),
    .view_o   (view)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_done_o   <= 1'b0;
      rsp_bad_op_o <= 1'b0;
      rsp_rdata_o  <= '0;
    end else begin
      rsp_done_o   <= req_valid_i;
      rsp_bad_op_o <= req_valid_i && !(is_wr || is_rd);
      if (req_valid_i && is_rd) rsp_rdata_o <= addr_hit ? view : 16'hFFFF;
    end
  end

  p_done_follows_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_done_o);
  p_no_stray_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_done_o);
  p_bad_op_with_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_bad_op_o |-> rsp_done_o);
  p_rdata_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_op_i == OP_RD) |=> $stable(rsp_rdata_o));
  p_foreign_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == OP_RD && req_phy_i != OWN_ADDR)
      |=> rsp_rdata_o == 16'hFFFF);
  p_speed_fixed_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == OP_RD && req_phy_i == OWN_ADDR
     && req_reg_i == IDX_SPEED) |=> rsp_rdata_o == 16'h8000);
  p_status_down_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == OP_RD && req_phy_i == OWN_ADDR
     && req_reg_i == IDX_STATUS && !link_q) |=> rsp_rdata_o == 16'h0000);
endmodule

// File: tb/phy_mgmt_responder_test.sv
module phy_mgmt_responder_test;
  localparam int CLK_P = 10;
  localparam int N_VEC = 32;

  typedef struct packed {
    logic [1:0]  op;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] wd;
    logic        lk;
    logic [15:0] exp;
    logic [3:0]  rq;
  } vec_t;

  // op: 1 write, 2 read; exp checked on reads only
  localparam vec_t VECS [N_VEC] = '{
    '{2'd2, 5'd7, 5'd0,  16'h0000, 1'b1, 16'h3100, 4'd1},  // R1
    '{2'd2, 5'd7, 5'd2,  16'h0000, 1'b1, 16'h0300, 4'd1},
    '{2'd2, 5'd7, 5'd3,  16'h0000, 1'b1, 16'hE400, 4'd1},
    '{2'd2, 5'd7, 5'd4,  16'h0000, 1'b1, 16'h01E1, 4'd1},
    '{2'd2, 5'd7, 5'd31, 16'h0000, 1'b1, 16'h0000, 4'd1},
    '{2'd2, 5'd7, 5'd1,  16'h0000, 1'b1, 16'h782E, 4'd4},  // R4
    '{2'd2, 5'd7, 5'd5,  16'h0000, 1'b1, 16'h41E1, 4'd5},  // R5
    '{2'd2, 5'd7, 5'd17, 16'h0000, 1'b1, 16'h8000, 4'd6},  // R6
    '{2'd2, 5'd7, 5'd18, 16'h0000, 1'b1, 16'h0C00, 4'd7},  // R7
    '{2'd1, 5'd7, 5'd4,  16'h0080, 1'b1, 16'h0000, 4'd3},
    '{2'd2, 5'd7, 5'd18, 16'h0000, 1'b1, 16'h0400, 4'd7},
    '{2'd2, 5'd7, 5'd5,  16'h0000, 1'b1, 16'h4081, 4'd5},
    '{2'd1, 5'd7, 5'd4,  16'h0040, 1'b1, 16'h0000, 4'd3},
    '{2'd2, 5'd7, 5'd18, 16'h0000, 1'b1, 16'h0800, 4'd7},
    '{2'd1, 5'd7, 5'd4,  16'h0100, 1'b1, 16'h0000, 4'd3},
    '{2'd2, 5'd7, 5'd18, 16'h0000, 1'b1, 16'h0C00, 4'd7},
    '{2'd1, 5'd7, 5'd4,  16'h0000, 1'b1, 16'h0000, 4'd3},
    '{2'd2, 5'd7, 5'd18, 16'h0000, 1'b1, 16'h0000, 4'd7},
    '{2'd2, 5'd7, 5'd5,  16'h0000, 1'b1, 16'h4001, 4'd5},
    '{2'd1, 5'd7, 5'd17, 16'h1234, 1'b1, 16'h0000, 4'd6},
    '{2'd2, 5'd7, 5'd17, 16'h0000, 1'b1, 16'h8000, 4'd6},
    '{2'd1, 5'd7, 5'd9,  16'hA5A5, 1'b1, 16'h0000, 4'd3},  // R3
    '{2'd2, 5'd7, 5'd9,  16'h0000, 1'b1, 16'hA5A5, 4'd3},
    '{2'd1, 5'd3, 5'd9,  16'h0F0F, 1'b1, 16'h0000, 4'd8},  // R8
    '{2'd2, 5'd3, 5'd9,  16'h0000, 1'b1, 16'hFFFF, 4'd8},
    '{2'd2, 5'd7, 5'd9,  16'h0000, 1'b1, 16'hA5A5, 4'd8},
    '{2'd1, 5'd7, 5'd4,  16'h01E1, 1'b1, 16'h0000, 4'd3},
    '{2'd2, 5'd7, 5'd1,  16'h0000, 1'b0, 16'h0000, 4'd4},
    '{2'd2, 5'd7, 5'd18, 16'h0000, 1'b0, 16'h0000, 4'd7},
    '{2'd2, 5'd7, 5'd5,  16'h0000, 1'b0, 16'h41E1, 4'd5},
    '{2'd1, 5'd7, 5'd0,  16'hBEEF, 1'b1, 16'h0000, 4'd3},
    '{2'd2, 5'd7, 5'd0,  16'h0000, 1'b1, 16'hBEEF, 4'd3}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        link_up_i = 1'b1;
  logic        req_valid_i = 1'b0;
  logic [4:0]  req_phy_i = '0;
  logic [4:0]  req_reg_i = '0;
  logic [1:0]  req_op_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic        rsp_done_o, rsp_bad_op_o;
  logic [15:0] rsp_rdata_o;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  phy_mgmt_responder uut (
    .clk_i(clk), .rst_ni(rst_ni), .link_up_i(link_up_i),
    .req_valid_i(req_valid_i), .req_phy_i(req_phy_i), .req_reg_i(req_reg_i),
    .req_op_i(req_op_i), .req_wdata_i(req_wdata_i),
    .rsp_done_o(rsp_done_o), .rsp_rdata_o(rsp_rdata_o), .rsp_bad_op_o(rsp_bad_op_o)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // issue one request; returns at the negedge after the sampling edge
  task automatic do_req(input logic [1:0] op, input logic [4:0] phy,
                        input logic [4:0] rg, input logic [15:0] wd);
    @(negedge clk);
    req_valid_i = 1'b1; req_op_i = op; req_phy_i = phy;
    req_reg_i = rg; req_wdata_i = wd;
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 done after reset", {15'b0, rsp_done_o}, 16'h0);
    check("R1 bad after reset", {15'b0, rsp_bad_op_o}, 16'h0);
    check("R1 rdata after reset", rsp_rdata_o, 16'h0);

    for (int i = 0; i < N_VEC; i++) begin
      if (link_up_i !== VECS[i].lk) begin
        link_up_i = VECS[i].lk;
        @(negedge clk);
      end
      do_req(VECS[i].op, VECS[i].phy, VECS[i].rg, VECS[i].wd);
      check($sformatf("R2 done vec %0d", i), {15'b0, rsp_done_o}, 16'h1);
      if (VECS[i].op == 2'd2)
        check($sformatf("R%0d vec %0d", VECS[i].rq, i), rsp_rdata_o, VECS[i].exp);
    end

    // R2: pulse is one cycle wide
    @(negedge clk);
    check("R2 done drops", {15'b0, rsp_done_o}, 16'h0);

    // R9: invalid op codes
    do_req(2'd0, 5'd7, 5'd9, 16'h1111);
    check("R9 bad op0", {15'b0, rsp_bad_op_o}, 16'h1);
    check("R9 done op0", {15'b0, rsp_done_o}, 16'h1);
    check("R9 rdata kept op0", rsp_rdata_o, 16'hBEEF);
    do_req(2'd3, 5'd7, 5'd9, 16'h2222);
    check("R9 bad op3", {15'b0, rsp_bad_op_o}, 16'h1);
    do_req(2'd3, 5'd3, 5'd9, 16'h0000);
    check("R9 bad op3 foreign", {15'b0, rsp_bad_op_o}, 16'h1);
    do_req(2'd2, 5'd7, 5'd9, 16'h0000);
    check("R9 reg untouched", rsp_rdata_o, 16'hA5A5);
    check("R9 no flag on read", {15'b0, rsp_bad_op_o}, 16'h0);

    // R10: write and idle hold read data
    do_req(2'd1, 5'd7, 5'd10, 16'h7777);
    check("R10 hold on write", rsp_rdata_o, 16'hA5A5);
    repeat (3) @(negedge clk);
    check("R10 hold idle", rsp_rdata_o, 16'hA5A5);

    // R11: link drop coincides with status read
    @(negedge clk);
    link_up_i = 1'b0;
    req_valid_i = 1'b1; req_op_i = 2'd2; req_phy_i = 5'd7; req_reg_i = 5'd1;
    @(negedge clk);
    req_valid_i = 1'b0;
    check("R11 read sees old link", rsp_rdata_o, 16'h782E);
    do_req(2'd2, 5'd7, 5'd1, 16'h0000);
    check("R11 read sees new link", rsp_rdata_o, 16'h0000);
    link_up_i = 1'b1;
    @(negedge clk);
    do_req(2'd2, 5'd7, 5'd18, 16'h0000);
    check("R7 link back", rsp_rdata_o, 16'h0C00);

    // R1: reset mid-run restores defaults
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    do_req(2'd2, 5'd7, 5'd9, 16'h0000);
    check("R1 stored reg cleared", rsp_rdata_o, 16'h0000);
    do_req(2'd2, 5'd7, 5'd0, 16'h0000);
    check("R1 reg0 restored", rsp_rdata_o, 16'h3100);

    finish_run();
  end
endmodule